// File: doc/BRIEF.md
# Test Instruction Register with Mode Decoder

This block holds the instruction of a boundary-scan test port. An eight-bit shift stage is filled serially while a TAP controller walks the instruction path, and an update stage latches the value. A decoder turns the latched code into the mode pins that the boundary cells and the output drivers use. The same block contains the one-bit bypass stage that the data path uses when the boundary register is not selected.

The device has no identification register. When the instruction path is captured, the shift stage loads a fixed pattern that is unique to the device, so a board test can recognise the part. The two lowest bits of that pattern are the 01 that the test standard requires. All serial data moves one bit per rising test-clock edge. The strobes come straight from the controller, so the serial interface has no handshake and no back-pressure. Only test reset, which is asynchronous and active low, can change the latched instruction without an update strobe.

Top module: `tap_ir_unit`

## Requirements
- R1: While `trst_n` is low and after it rises, the decoded instruction is BYPASS: `byp_select`=1 and the other four mode outputs are 0. `ir_so`=1 (the shift stage holds the capture pattern), and `byp_so`=0.
- R2: A clock edge with `capture_ir` high loads the shift stage with 8'b0011_1101. Later shifts present it on `ir_so` LSB first: 1,0,1,1,1,1,0,0.
- R3: A clock edge with `shift_ir` high (and `capture_ir` low) moves the shift stage one place toward bit 0. `tdi` enters bit 7 and `ir_so` shows bit 0. After eight shifts the stage holds the eight `tdi` bits, the first one at bit 0.
- R4: The decoded outputs change only on the clock edge after `update_ir` is high, or on test reset. Capture and shift leave them unchanged.
- R5: Code 8'h00 (EXTEST) gives `bnd_drive`=1 and `bnd_select`=1, with `clamp_en`, `highz_en` and `byp_select` all 0.
- R6: Code 8'h81 (SAMPLE/PRELOAD) gives `bnd_select`=1 and all other mode outputs 0.
- R7: Code 8'h82 (CLAMP) gives `bnd_drive`=1, `clamp_en`=1 and `byp_select`=1, with `bnd_select`=0 and `highz_en`=0.
- R8: Code 8'h03 (HIGHZ) gives `highz_en`=1 and `byp_select`=1, with the other three outputs 0.
- R9: Every other code gives `byp_select`=1 alone. Exactly one of `bnd_select` and `byp_select` is high at all times.
- R10: A clock edge with `capture_dr` high loads 0 into the bypass stage. A clock edge with `shift_dr` high loads `tdi`. `byp_so` shows the stage.
- R11: Capture takes priority over shift in the same cycle, for both the instruction path and the bypass path.
- R12: Driving `trst_n` low forces BYPASS at once, with no clock edge, whatever instruction was latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data in |
| capture_ir | input | 1 | Capture strobe for the instruction path |
| shift_ir | input | 1 | Shift strobe for the instruction path |
| update_ir | input | 1 | Update strobe for the instruction path |
| capture_dr | input | 1 | Capture strobe for the bypass stage |
| shift_dr | input | 1 | Shift strobe for the bypass stage |
| ir_so | output | 1 | Serial out of the instruction shift stage |
| byp_so | output | 1 | Serial out of the bypass stage |
| bnd_drive | output | 1 | Pins are driven from the boundary update stages |
| bnd_select | output | 1 | Boundary register is the selected data path |
| clamp_en | output | 1 | Clamp mode is active |
| highz_en | output | 1 | All system outputs are forced to high impedance |
| byp_select | output | 1 | Bypass stage is the selected data path |

## Verification
The assertions check four things on every cycle. The capture pattern and the one-place shift must hold in the instruction stage. The latched instruction must stay stable unless an update strobe occurred. The bypass stage must load zero on capture. The clamp and high-impedance modes must be consistent, and exactly one data path may be selected. The bench scenarios cover the rest: that each code gives its own set of mode pins, that the captured identifier comes out in the right serial order, that capture beats shift, and that an asynchronous reset in the middle of an instruction falls back to bypass.

// File: rtl/tir_pkg.sv
package tir_pkg;

  localparam int IR_W = 8;

  localparam logic [IR_W-1:0] IR_CAPTURE = 8'b0011_1101;
  localparam logic [IR_W-1:0] OP_EXTEST  = 8'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 8'h81;
  localparam logic [IR_W-1:0] OP_CLAMP   = 8'h82;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 8'h03;
  localparam logic [IR_W-1:0] OP_BYPASS  = {IR_W{1'b1}};

  typedef struct packed {
    logic drive;
    logic bsel;
    logic clamp;
    logic hz;
    logic byp;
  } mode_t;

endpackage

// File: rtl/tir_shreg.sv
module tir_shreg #(
  parameter int W = 8,
  parameter logic [W-1:0] CAP = '0
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         sdi,
  input  logic         cap,
  input  logic         shf,
  output logic [W-1:0] q,
  output logic         so
);

  logic [W-1:0] shifted;

  // each bit takes its upper neighbour; the top bit takes serial input
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign shifted[i] = sdi;
    end else begin : g_mid
      assign shifted[i] = q[i+1];
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)   q <= CAP;
    else if (cap)  q <= CAP;
    else if (shf)  q <= shifted;
  end

  assign so = q[0];

  // R2: capture loads the fixed pattern
  p_capture_pattern_r2: assert property (@(posedge tck) disable iff (!trst_n)
    cap |=> (q == CAP));

  // R3 / R11: a shift without capture moves one place toward bit 0
  p_shift_step_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (shf && !cap) |=> (q[W-1] == $past(sdi)) && (q[W-2:0] == $past(q[W-1:1])));

  // R3: no strobe, no change
  p_hold_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (!shf && !cap) |=> $stable(q));

endmodule

// File: rtl/tir_update.sv
module tir_update #(
  parameter int W = 8,
  parameter logic [W-1:0] RST = '1
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         upd,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)  q <= RST;
    else if (upd) q <= d;
  end

  // R4: latched instruction moves only on an update strobe
  p_active_stable_r4: assert property (@(posedge tck) disable iff (!trst_n)
    !upd |=> $stable(q));

  // R4: update takes the shift stage contents
  p_update_load_r4: assert property (@(posedge tck) disable iff (!trst_n)
    upd |=> (q == $past(d)));

endmodule

// File: rtl/tir_decode.sv
module tir_decode
  import tir_pkg::*;
(
  input  logic [IR_W-1:0] op,
  output mode_t           mode
);

  always_comb begin
    mode = '0;
    unique case (op)
      OP_EXTEST: begin
        mode.drive = 1'b1;
        mode.bsel  = 1'b1;
      end
      OP_SAMPLE: begin
        mode.bsel  = 1'b1;
      end
      OP_CLAMP: begin
        mode.drive = 1'b1;
        mode.clamp = 1'b1;
        mode.byp   = 1'b1;
      end
      OP_HIGHZ: begin
        mode.hz    = 1'b1;
        mode.byp   = 1'b1;
      end
      default: begin
        mode.byp   = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/tir_bypass_cell.sv
module tir_bypass_cell #(
  parameter logic CAP_VAL = 1'b0
) (
  input  logic tck,
  input  logic trst_n,
  input  logic sdi,
  input  logic cap,
  input  logic shf,
  output logic so
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)  so <= CAP_VAL;
    else if (cap) so <= CAP_VAL;
    else if (shf) so <= sdi;
  end

  // R10: capture loads the constant
  p_byp_capture_r10: assert property (@(posedge tck) disable iff (!trst_n)
    cap |=> (so == CAP_VAL));

  // R10 / R11: shift alone passes serial input through one stage
  p_byp_shift_r10: assert property (@(posedge tck) disable iff (!trst_n)
    (shf && !cap) |=> (so == $past(sdi)));

endmodule

// File: rtl/tap_ir_unit.sv
module tap_ir_unit
  import tir_pkg::*;
(
  input  logic tck,
  input  logic trst_n,
  input  logic tdi,
  input  logic capture_ir,
  input  logic shift_ir,
  input  logic update_ir,
  input  logic capture_dr,
  input  logic shift_dr,
  output logic ir_so,
  output logic byp_so,
  output logic bnd_drive,
  output logic bnd_select,
  output logic clamp_en,
  output logic highz_en,
  output logic byp_select
);

  logic [IR_W-1:0] ir_shift;
  logic [IR_W-1:0] ir_active;
  mode_t           mode;

  tir_shreg #(.W(IR_W), .CAP(IR_CAPTURE)) u_shift (
    .tck(tck), .trst_n(trst_n), .sdi(tdi),
    .cap(capture_ir), .shf(shift_ir),
    .q(ir_shift), .so(ir_so)
  );

  tir_update #(.W(IR_W), .RST(OP_BYPASS)) u_update (
    .tck(tck), .trst_n(trst_n), .upd(update_ir),
    .d(ir_shift), .q(ir_active)
  );

  tir_decode u_decode (
    .op(ir_active), .mode(mode)
  );

  tir_bypass_cell #(.CAP_VAL(1'b0)) u_bypass (
    .tck(tck), .trst_n(trst_n), .sdi(tdi),
    .cap(capture_dr), .shf(shift_dr), .so(byp_so)
  );

  assign bnd_drive  = mode.drive;
  assign bnd_select = mode.bsel;
  assign clamp_en   = mode.clamp;
  assign highz_en   = mode.hz;
  assign byp_select = mode.byp;

  // R9: exactly one data path is selected
  p_one_path_r9: assert property (@(posedge tck) disable iff (!trst_n)
    $countones({bnd_select, byp_select}) == 1);

  // R7: clamp drives the pins while bypass is selected
  p_clamp_shape_r7: assert property (@(posedge tck) disable iff (!trst_n)
    clamp_en |-> (bnd_drive && byp_select && !highz_en));

  // R8: high impedance never coexists with driving from boundary cells
  p_highz_shape_r8: assert property (@(posedge tck) disable iff (!trst_n)
    highz_en |-> (!bnd_drive && byp_select && !clamp_en));

  // R4: mode pins are steady without an update strobe
  p_mode_stable_r4: assert property (@(posedge tck) disable iff (!trst_n)
    !update_ir |=> $stable({bnd_drive, bnd_select, clamp_en, highz_en, byp_select}));

endmodule

// File: tb/test_tap_ir_unit.sv
module test_tap_ir_unit;

  localparam int PERIOD = 10;
  localparam logic [7:0] CAP_PAT = 8'b0011_1101;
  // flag order {drive, bsel, clamp, hz, byp}
  localparam logic [4:0] F_BYP = 5'b00001;
  localparam int NVEC = 9;
  localparam logic [12:0] VEC [NVEC] = '{
    {8'h00, 5'b11000},   // R5 EXTEST
    {8'h81, 5'b01000},   // R6 SAMPLE
    {8'h82, 5'b10101},   // R7 CLAMP
    {8'h03, 5'b00011},   // R8 HIGHZ
    {8'hFF, 5'b00001},   // R9
    {8'h01, 5'b00001},   // R9
    {8'h80, 5'b00001},   // R9
    {8'h83, 5'b00001},   // R9
    {8'h02, 5'b00001}    // R9
  };

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tdi = 1'b0;
  logic capture_ir = 1'b0, shift_ir = 1'b0, update_ir = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0;
  logic ir_so, byp_so, bnd_drive, bnd_select, clamp_en, highz_en, byp_select;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(PERIOD/2) tck = ~tck;

  tap_ir_unit i_tap_ir_unit (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
    .capture_dr(capture_dr), .shift_dr(shift_dr),
    .ir_so(ir_so), .byp_so(byp_so),
    .bnd_drive(bnd_drive), .bnd_select(bnd_select), .clamp_en(clamp_en),
    .highz_en(highz_en), .byp_select(byp_select)
  );

  function automatic logic [4:0] flags();
    return {bnd_drive, bnd_select, clamp_en, highz_en, byp_select};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck);
    #1;
  endtask

  // capture, shift code in LSB first, update; checks identifier bits and hold
  task automatic load_ir(input logic [7:0] code, input logic [4:0] prev);
    capture_ir = 1'b1;
    tick();
    capture_ir = 1'b0;
    shift_ir = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tdi = code[i];
      check("R2 id bit", {7'd0, ir_so}, {7'd0, CAP_PAT[i]});
      tick();
    end
    shift_ir = 1'b0;
    check("R3 shifted lsb", {7'd0, ir_so}, {7'd0, code[0]});
    check("R4 hold before update", {3'd0, flags()}, {3'd0, prev});
    update_ir = 1'b1;
    tick();
    update_ir = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [4:0] prev;
    #(PERIOD * 3);
    check("R1 reset flags", {3'd0, flags()}, {3'd0, F_BYP});
    trst_n = 1'b1;
    tick();
    check("R1 flags after reset", {3'd0, flags()}, {3'd0, F_BYP});
    check("R1 ir_so", {7'd0, ir_so}, 8'd1);
    check("R1 byp_so", {7'd0, byp_so}, 8'd0);

    prev = F_BYP;
    for (int v = 0; v < NVEC; v++) begin
      load_ir(VEC[v][12:5], prev);
      check("R5-9 decode", {3'd0, flags()}, {3'd0, VEC[v][4:0]});
      prev = VEC[v][4:0];
    end

    // R3: full byte comes out in order after a second load
    capture_ir = 1'b1; tick(); capture_ir = 1'b0;
    shift_ir = 1'b1;
    for (int i = 0; i < 8; i++) begin tdi = 8'hA6 >> i; tick(); end
    for (int i = 0; i < 8; i++) begin
      check("R3 serial order", {7'd0, ir_so}, {7'd0, 8'hA6 >> i & 8'd1});
      tdi = 1'b0; tick();
    end
    shift_ir = 1'b0;
    check("R4 no update keeps mode", {3'd0, flags()}, {3'd0, prev});

    // R11: capture beats shift on the instruction path
    tdi = 1'b0; capture_ir = 1'b1; shift_ir = 1'b1; tick();
    capture_ir = 1'b0;
    check("R11 ir capture wins", {7'd0, ir_so}, 8'd1);
    tick();
    shift_ir = 1'b0;
    check("R11 ir next bit", {7'd0, ir_so}, 8'd0);

    // R10: bypass stage
    tdi = 1'b1; shift_dr = 1'b1; tick();
    check("R10 shift one", {7'd0, byp_so}, 8'd1);
    shift_dr = 1'b0; capture_dr = 1'b1; tick(); capture_dr = 1'b0;
    check("R10 capture zero", {7'd0, byp_so}, 8'd0);
    shift_dr = 1'b1; tdi = 1'b1; tick();
    check("R10 shift in 1", {7'd0, byp_so}, 8'd1);
    tdi = 1'b0; tick();
    check("R10 shift in 0", {7'd0, byp_so}, 8'd0);
    tdi = 1'b1; tick();
    capture_dr = 1'b1; tick(); capture_dr = 1'b0; shift_dr = 1'b0;
    check("R11 dr capture wins", {7'd0, byp_so}, 8'd0);

    // R12: asynchronous reset out of EXTEST
    load_ir(8'h00, prev);
    check("R5 extest again", {3'd0, flags()}, {3'd0, 5'b11000});
    #(PERIOD/4);
    trst_n = 1'b0;
    #1;
    check("R12 async bypass", {3'd0, flags()}, {3'd0, F_BYP});
    check("R12 ir_so pattern", {7'd0, ir_so}, 8'd1);
    #(PERIOD);
    trst_n = 1'b1;
    tick();
    check("R12 after release", {3'd0, flags()}, {3'd0, F_BYP});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule